// File: doc/BRIEF.md
# Double-Buffered Banked Operand Feeder

This block keeps two copies of a banked operand store, a write half and a read half. A producer streams load words into the write half. Each word carries a short vector of elements, and consecutive rows of elements are dealt out round-robin across the banks. The read half serves requesters at the same time. There is one request/response port pair per bank, and each accepted request returns a fixed-length burst of elements from one row of that port's bank. Loads into one half and burst reads from the other proceed in the same cycle, with no stall between them.

Each bank has a consumer that reports when it has finished with the current block, and the block latches these reports. Once every consumer has reported, all of them receive a one-cycle acknowledge together. The halves exchange roles only when the write half holds a complete block and one of two things is true: every consumer has reported, or this is the very first block. On the exchange the fill state, the open bursts and the done reports are all cleared. Until the first exchange the block accepts no requests.

Top module: `dbuf_operand_feeder`

## Requirements
- R1: After a synchronous active-high reset, `ldReady` is 1, `reqReady`, `rspValid` and `ackPulse` are all 0, and `doneReady` is all 1.
- R2: Before the first half exchange, no request is accepted (`reqReady` is 0 on every port) and no response is offered (`rspValid` is 0).
- R3: Load word w of a block (counted from 0 within the block) carries `VEC_W` elements, with element v in bits `[v*DATA_W +: DATA_W]`. Row `w/(BURST_LEN/VEC_W)` goes to bank `row mod NB`, at bank address `(row/NB)*BURST_LEN`, offset by the element position within the row. That position is `(w mod (BURST_LEN/VEC_W))*VEC_W + v`.
- R4: Once `ROWS*BURST_LEN/VEC_W` words have been accepted, `ldReady` stays 0 until the next exchange.
- R5: A request with row address a on port `a mod NB` returns `BURST_LEN` elements in order. They are read from bank addresses `(a/NB)*BURST_LEN + k`, for k = 0 up to `BURST_LEN-1`, in the read half.
- R6: A port whose burst is in progress holds `reqReady` at 0. It raises `reqReady` again in the cycle after the handshake of the last element.
- R7: While `rspValid` is 1 and `rspReady` is 0, `rspData` of that port holds its value.
- R8: Done reports are latched per bank. In the cycle after the last missing report is latched, `ackPulse` is 1 on every bank for exactly one cycle. It does not repeat before the next exchange.
- R9: The halves exchange in the cycle in which the load count is full and either all done reports are latched or no exchange has yet happened. Data loaded since the previous exchange becomes readable only after the exchange. Afterwards loading restarts and done reports are cleared.
- R10: Loading the write half while bursts are read from the read half neither stalls either side nor changes any returned element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldValid | input | 1 | Load word valid |
| ldReady | output | 1 | Load word accepted when high |
| ldData | input | VEC_W*DATA_W | Load word, element v in slice v |
| reqValid | input | NB | Per-port request valid |
| reqReady | output | NB | Per-port request ready |
| reqRow | input | NB*ROW_W | Per-port row address |
| rspValid | output | NB | Per-port response element valid |
| rspReady | input | NB | Per-port response ready |
| rspData | output | NB*DATA_W | Per-port response element |
| doneValid | input | NB | Per-bank consumer done report |
| doneReady | output | NB | Done report accepted when high |
| ackPulse | output | NB | One-cycle acknowledge to all consumers |

## Verification
The bench uses 2 banks, 4 rows, bursts of 4 and vectors of 2. Every element value is a distinct arithmetic function of block, row and position, so a wrong bank, wrong offset or stale half shows up as a wrong value. Every row of three successive blocks is read back. Each burst alternates stalled and immediate response handshakes, which checks both that data is held and that elements come out in order. The first block is read on both ports at once while the next block loads, which separates a hazard-free design from one that stalls or corrupts data. The done reports arrive once after the load is full and once before it, which checks that the acknowledge fires a single time and that the exchange waits for both conditions.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

  // strobes from the control to the storage datapath
  typedef struct packed {
    logic wrEn;    // write the current load word
    logic wrHalf;  // half receiving loads
    logic rdHalf;  // half serving bursts
    logic swap;    // halves exchange at the next edge
  } feedStrobe_t;

endpackage

// File: rtl/feeder_bank_ram.sv
module feeder_bank_ram #(
  parameter int DATA_W = 8,
  parameter int VEC_W  = 2,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [VEC_W*DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [DATA_W-1:0]       rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  // one vector lands at consecutive addresses
  always_ff @(posedge clk) begin
    if (wrEn) begin
      for (int v = 0; v < VEC_W; v++) begin
        mem[ADDR_W'(wrAddr + ADDR_W'(v))] <= wrData[v*DATA_W +: DATA_W];
      end
    end
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/feeder_datapath.sv
module feeder_datapath
  import feeder_pkg::*;
#(
  parameter int NB     = 2,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 2,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3,
  parameter int BANK_W = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  feedStrobe_t             strobe,
  input  logic [BANK_W-1:0]       wrBank,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [VEC_W*DATA_W-1:0] ldData,
  input  logic [NB*ADDR_W-1:0]    rdAddr,
  output logic [NB*DATA_W-1:0]    rspData
);

  logic [DATA_W-1:0] halfData [2][NB];

  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar b = 0; b < NB; b++) begin : g_bank
      feeder_bank_ram #(
        .DATA_W(DATA_W), .VEC_W(VEC_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
      ) u_ram (
        .clk   (clk),
        .wrEn  (strobe.wrEn && (strobe.wrHalf == 1'(h)) && (wrBank == BANK_W'(b))),
        .wrAddr(wrAddr),
        .wrData(ldData),
        .rdAddr(rdAddr[b*ADDR_W +: ADDR_W]),
        .rdData(halfData[h][b])
      );
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_out
    assign rspData[b*DATA_W +: DATA_W] = strobe.rdHalf ? halfData[1][b] : halfData[0][b];
  end

  // halves never coincide, and no load lands in the exchange cycle
  AST_HALVES_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    strobe.wrHalf != strobe.rdHalf); // R10
  AST_NO_WRITE_ON_SWAP: assert property (@(posedge clk) disable iff (rst)
    strobe.swap |-> !strobe.wrEn); // R4

endmodule

// File: rtl/feeder_ctrl.sv
module feeder_ctrl
  import feeder_pkg::*;
#(
  parameter int NB        = 2,
  parameter int ROWS      = 4,
  parameter int BURST_LEN = 4,
  parameter int VEC_W     = 2,
  parameter int ADDR_W    = 3,
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ldValid,
  output logic                 ldReady,
  input  logic [NB-1:0]        reqValid,
  output logic [NB-1:0]        reqReady,
  input  logic [NB*ROW_W-1:0]  reqRow,
  output logic [NB-1:0]        rspValid,
  input  logic [NB-1:0]        rspReady,
  input  logic [NB-1:0]        doneValid,
  output logic [NB-1:0]        doneReady,
  output logic [NB-1:0]        ackPulse,
  output feedStrobe_t          strobe,
  output logic [BANK_W-1:0]    wrBank,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [NB*ADDR_W-1:0] rdAddr
);

  localparam int WPR        = BURST_LEN / VEC_W;
  localparam int FULL_WORDS = ROWS * WPR;
  localparam int WC_W       = $clog2(FULL_WORDS + 1);
  localparam int BL_W       = $clog2(BURST_LEN + 1);

  logic [WC_W-1:0]   wordCnt;
  logic [ADDR_W-1:0] fillPtr   [NB];
  logic [BL_W-1:0]   burstCnt  [NB];
  logic [ADDR_W-1:0] startAddr [NB];
  logic [ADDR_W-1:0] startNext [NB];
  logic [NB-1:0]     busy, doneFlag;
  logic              ackSent, first, phase;
  logic              loadFull, allDone, swap, ldFire;

  assign loadFull = (wordCnt == WC_W'(FULL_WORDS));
  assign allDone  = &doneFlag;
  assign swap     = loadFull && (allDone || first);
  assign ldReady  = !loadFull;
  assign ldFire   = ldValid && ldReady;

  assign wrBank   = BANK_W'((wordCnt / WC_W'(WPR)) % WC_W'(NB));
  assign wrAddr   = fillPtr[wrBank];

  assign ackPulse  = {NB{allDone && !ackSent}};
  assign doneReady = {NB{!swap}};
  assign rspValid  = busy;

  assign strobe.wrEn   = ldFire;
  assign strobe.wrHalf = phase;
  assign strobe.rdHalf = !phase;
  assign strobe.swap   = swap;

  for (genvar i = 0; i < NB; i++) begin : g_port
    assign reqReady[i] = !busy[i] && !first && !swap;
    assign startNext[i] = ADDR_W'((int'(reqRow[i*ROW_W +: ROW_W]) / NB) * BURST_LEN);
    assign rdAddr[i*ADDR_W +: ADDR_W] = ADDR_W'(startAddr[i] + ADDR_W'(burstCnt[i]));

    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (rst)
      busy[i] |-> (burstCnt[i] < BL_W'(BURST_LEN))); // R5
    AST_PORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (busy[i] && rspReady[i] && !swap && burstCnt[i] == BL_W'(BURST_LEN-1)) |=> reqReady[i]); // R6
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordCnt  <= '0;
      busy     <= '0;
      doneFlag <= '0;
      ackSent  <= 1'b0;
      first    <= 1'b1;
      phase    <= 1'b0;
      for (int i = 0; i < NB; i++) begin
        fillPtr[i]   <= '0;
        burstCnt[i]  <= '0;
        startAddr[i] <= '0;
      end
    end else if (swap) begin
      wordCnt  <= '0;
      busy     <= '0;
      doneFlag <= '0;
      ackSent  <= 1'b0;
      first    <= 1'b0;
      phase    <= !phase;
      for (int i = 0; i < NB; i++) begin
        fillPtr[i] <= '0;
      end
    end else begin
      if (ldFire) begin
        wordCnt         <= wordCnt + 1'b1;
        fillPtr[wrBank] <= ADDR_W'(fillPtr[wrBank] + ADDR_W'(VEC_W));
      end
      doneFlag <= doneFlag | doneValid;
      if (allDone && !ackSent) begin
        ackSent <= 1'b1;
      end
      for (int i = 0; i < NB; i++) begin
        if (reqValid[i] && reqReady[i]) begin
          busy[i]      <= 1'b1;
          burstCnt[i]  <= '0;
          startAddr[i] <= startNext[i];
        end else if (busy[i] && rspReady[i]) begin
          burstCnt[i] <= burstCnt[i] + 1'b1;
          if (burstCnt[i] == BL_W'(BURST_LEN-1)) begin
            busy[i] <= 1'b0;
          end
        end
      end
    end
  end

  AST_QUIET_BEFORE_FIRST: assert property (@(posedge clk) disable iff (rst)
    first |-> (rspValid == '0 && reqReady == '0)); // R2
  AST_WORD_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    wordCnt <= WC_W'(FULL_WORDS)); // R4
  AST_ACK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (|ackPulse) |=> !(|ackPulse)); // R8
  AST_SWAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    swap |=> (ldReady && rspValid == '0 && doneFlag == '0 && phase != $past(phase))); // R9

endmodule

// File: rtl/dbuf_operand_feeder.sv
module dbuf_operand_feeder
  import feeder_pkg::*;
#(
  parameter int NB        = 2,
  parameter int DATA_W    = 8,
  parameter int ROWS      = 4,
  parameter int BURST_LEN = 4,
  parameter int VEC_W     = 2,
  parameter int ROW_W     = $clog2(ROWS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ldValid,
  output logic                    ldReady,
  input  logic [VEC_W*DATA_W-1:0] ldData,
  input  logic [NB-1:0]           reqValid,
  output logic [NB-1:0]           reqReady,
  input  logic [NB*ROW_W-1:0]     reqRow,
  output logic [NB-1:0]           rspValid,
  input  logic [NB-1:0]           rspReady,
  output logic [NB*DATA_W-1:0]    rspData,
  input  logic [NB-1:0]           doneValid,
  output logic [NB-1:0]           doneReady,
  output logic [NB-1:0]           ackPulse
);

  localparam int DEPTH  = (ROWS / NB) * BURST_LEN;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BANK_W = $clog2(NB);

  feedStrobe_t         strobe;
  logic [BANK_W-1:0]   wrBank;
  logic [ADDR_W-1:0]   wrAddr;
  logic [NB*ADDR_W-1:0] rdAddr;

  feeder_ctrl #(
    .NB(NB), .ROWS(ROWS), .BURST_LEN(BURST_LEN), .VEC_W(VEC_W),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .ldValid(ldValid), .ldReady(ldReady),
    .reqValid(reqValid), .reqReady(reqReady), .reqRow(reqRow),
    .rspValid(rspValid), .rspReady(rspReady),
    .doneValid(doneValid), .doneReady(doneReady), .ackPulse(ackPulse),
    .strobe(strobe), .wrBank(wrBank), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  feeder_datapath #(
    .NB(NB), .DATA_W(DATA_W), .VEC_W(VEC_W), .DEPTH(DEPTH),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .wrBank(wrBank), .wrAddr(wrAddr), .ldData(ldData),
    .rdAddr(rdAddr), .rspData(rspData)
  );

  for (genvar i = 0; i < NB; i++) begin : g_hold
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rspValid[i] && !rspReady[i] && !strobe.swap)
        |=> (rspValid[i] && $stable(rspData[i*DATA_W +: DATA_W]))); // R7
  end

endmodule

// File: tb/dbuf_operand_feeder_tb.sv
module dbuf_operand_feeder_tb;

  localparam int NB = 2, DW = 8, ROWS = 4, BL = 4, VW = 2, RW = 2;
  localparam int WORDS = ROWS * BL / VW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ldValid = 1'b0;
  logic ldReady;
  logic [VW*DW-1:0] ldData = '0;
  logic [NB-1:0] reqValid = '0, reqReady, rspValid, rspReady = '0;
  logic [NB-1:0] doneValid = '0, doneReady, ackPulse;
  logic [NB*RW-1:0] reqRow = '0;
  logic [NB*DW-1:0] rspData;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dbuf_operand_feeder #(
    .NB(NB), .DATA_W(DW), .ROWS(ROWS), .BURST_LEN(BL), .VEC_W(VW)
  ) u_dut (
    .clk(clk), .rst(rst),
    .ldValid(ldValid), .ldReady(ldReady), .ldData(ldData),
    .reqValid(reqValid), .reqReady(reqReady), .reqRow(reqRow),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .doneValid(doneValid), .doneReady(doneReady), .ackPulse(ackPulse)
  );

  function automatic logic [7:0] ev(int b, int row, int j);
    return 8'(b * 64 + row * 8 + j + 5);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // all tasks start and end at a falling edge
  task automatic loadWord(logic [VW*DW-1:0] d);
    ldValid = 1'b1;
    ldData  = d;
    while (!ldReady) @(negedge clk);
    @(negedge clk);
    ldValid = 1'b0;
  endtask

  task automatic loadBlock(int b, bit firstBlock);
    for (int w = 0; w < WORDS; w++) begin
      int row = w / (BL / VW);
      int j0  = (w % (BL / VW)) * VW;
      if (firstBlock) begin
        chk("R2 reqReady before first exchange", 32'(reqReady), 32'd0);
        chk("R2 rspValid before first exchange", 32'(rspValid), 32'd0);
      end
      loadWord({ev(b, row, j0 + 1), ev(b, row, j0)});
    end
  endtask

  task automatic readRow(int p, int row, int b, string tag);
    logic [7:0] held;
    reqValid[p] = 1'b1;
    reqRow[p*RW +: RW] = RW'(row);
    while (!reqReady[p]) @(negedge clk);
    @(negedge clk);
    reqValid[p] = 1'b0;
    chk("R6 reqReady low during burst", 32'(reqReady[p]), 32'd0);
    for (int k = 0; k < BL; k++) begin
      if (k % 2 == 0) begin
        rspReady[p] = 1'b0;
        held = rspData[p*DW +: DW];
        @(negedge clk);
        chk("R7 rspData held while stalled", 32'(rspData[p*DW +: DW]), 32'(held));
        chk("R7 rspValid held while stalled", 32'(rspValid[p]), 32'd1);
      end
      rspReady[p] = 1'b1;
      chk({tag, " R5 burst element"}, 32'(rspData[p*DW +: DW]), 32'(ev(b, row, k)));
      @(negedge clk);
      rspReady[p] = 1'b0;
    end
    chk("R6 reqReady after last element", 32'(reqReady[p]), 32'd1);
  endtask

  task automatic sendDone(int b);
    doneValid[b] = 1'b1;
    while (!doneReady[b]) @(negedge clk);
    @(negedge clk);
    doneValid[b] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ldReady", 32'(ldReady), 32'd1);
    chk("R1 reqReady", 32'(reqReady), 32'd0);
    chk("R1 rspValid", 32'(rspValid), 32'd0);
    chk("R1 ackPulse", 32'(ackPulse), 32'd0);
    chk("R1 doneReady", 32'(doneReady), 32'b11);

    // block 0, first exchange needs no done reports
    loadBlock(0, 1'b1);
    chk("R4 ldReady low when full", 32'(ldReady), 32'd0);
    chk("R9 no requests in exchange cycle", 32'(reqReady), 32'd0);
    @(negedge clk);
    chk("R9 ldReady after first exchange", 32'(ldReady), 32'd1);
    chk("R9 reqReady after first exchange", 32'(reqReady), 32'b11);

    // block 0 read on both ports while block 1 loads
    fork
      loadBlock(1, 1'b0);
      begin readRow(0, 0, 0, "R10"); readRow(0, 2, 0, "R10"); end
      begin readRow(1, 1, 0, "R10"); readRow(1, 3, 0, "R10"); end
    join
    repeat (2) @(negedge clk);
    chk("R4 ldReady stays low while waiting", 32'(ldReady), 32'd0);
    readRow(1, 1, 0, "R9 no exchange without done");

    sendDone(0);
    chk("R8 no ack with one report", 32'(ackPulse), 32'd0);
    sendDone(1);
    chk("R8 ack on all banks", 32'(ackPulse), 32'b11);
    chk("R9 still full in exchange cycle", 32'(ldReady), 32'd0);
    @(negedge clk);
    chk("R8 ack lasts one cycle", 32'(ackPulse), 32'd0);
    chk("R9 loading restarts", 32'(ldReady), 32'd1);
    for (int r = 0; r < ROWS; r++) readRow(r % NB, r, 1, "R9 block1");

    // block 2: reports arrive before the load completes
    sendDone(1);
    sendDone(0);
    chk("R8 ack before load full", 32'(ackPulse), 32'b11);
    chk("R9 no exchange while not full", 32'(ldReady), 32'd1);
    @(negedge clk);
    chk("R8 ack not repeated", 32'(ackPulse), 32'd0);
    loadBlock(2, 1'b0);
    chk("R8 no second ack at exchange", 32'(ackPulse), 32'd0);
    chk("R4 ldReady low at full", 32'(ldReady), 32'd0);
    @(negedge clk);
    chk("R9 exchange after full", 32'(ldReady), 32'd1);
    for (int r = ROWS - 1; r >= 0; r--) readRow(r % NB, r, 2, "R3 block2");

    summary();
  end

endmodule